// File: doc/BRIEF.md
# Programmable binary tap timer

This block divides a periodic enable pulse (`tick`) through a sixteen-stage binary counter and presents one selected counter stage as a single timing output `q`. A two-bit select chooses the stage. One select code does not tap the lower stages. Instead, it feeds the tick straight into the upper eight-stage section, so the top stage then divides by 2^8 rather than 2^16.

Two behaviours are available. In recycle mode the output follows the chosen stage continuously, which gives a 2^n frequency divider. In single-cycle mode a sticky latch flips the output once, after half of the selected count, and then holds it. The latch is re-armed by a master reset or by any change in the mode level. An output-polarity input sets the level of `q` while the block is cleared, and inverts the output in both modes. A power-on clear request is honoured only when the active-low auto-clear enable is asserted. All controls are sampled on `clk`.

Top module: `tap_timer`

## Requirements
- R1: While the block is cleared (rst_n low, mreset high, or an honoured power-on request), the counter is held at zero and `q` equals `pol_sel`.
- R2: mreset takes priority over tick in the same cycle. No count is gained while mreset is high, and a full count is needed after it falls.
- R3: por_req clears the counter only when arst_en_n is 0. When arst_en_n is 1, por_req has no effect on the count.
- R4: The counter advances by one only on clock edges where tick is 1. Cycles with tick 0 leave it unchanged.
- R5: The select code {sel_a,sel_b} maps as follows. 00 taps stage 13 (first change after 4096 ticks). 01 taps stage 10 (512 ticks). 11 taps stage 16 (32768 ticks). 10 clocks the upper section directly from tick, so stage 16 changes after 128 ticks.
- R6: With mode=1, q equals the selected stage XOR pol_sel. q first changes on the edge of tick number 2^(n-1) and returns after another 2^(n-1) ticks.
- R7: With mode=0, q changes to the inverse of pol_sel on the edge of tick number 2^(n-1) and then holds that level for any number of further ticks.
- R8: A change of the mode level seen on a clock edge clears the counter and re-arms the single-cycle latch, so q returns to pol_sel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| tick | input | 1 | Count enable, one count per high cycle |
| por_req | input | 1 | Power-on clear request |
| arst_en_n | input | 1 | Active-low enable for por_req |
| mreset | input | 1 | Master reset, active high |
| sel_a | input | 1 | Stage select, upper bit |
| sel_b | input | 1 | Stage select, lower bit |
| mode | input | 1 | 1 = recycle divider, 0 = single-cycle timer |
| pol_sel | input | 1 | Output polarity and level while cleared |
| q | output | 1 | Timing output |

## Verification
A miscounted counter section, or a carry taken at the wrong stage, moves the first transition of `q` away from the exact tick number. The bench pins that down by checking one tick before the transition and on it. A latch that does not stick shows up in single-cycle mode once the selected stage falls again, half a period after the flip. A clear source that is missed or honoured wrongly shows up as an early or late transition, by the number of ticks counted before the clear.

// File: rtl/tap_timer_pkg.sv
// Shared encodings for the tap timer.
// Assumes: the select is presented as {sel_a, sel_b}.
package tap_timer_pkg;
    typedef enum logic [1:0] {
        TAP_MID  = 2'b00,  // stage 13
        TAP_LOW  = 2'b01,  // stage 10
        TAP_SKIP = 2'b10,  // upper section fed by tick, top stage
        TAP_FULL = 2'b11   // stage 16 through both sections
    } tap_sel_e;
endpackage

// File: rtl/tt_clear_ctrl.sv
// Merges the clear sources into one synchronous clear and detects a mode-level change.
// Assumes: all inputs are synchronous to clk.
module tt_clear_ctrl (
    input  logic clk,
    input  logic mreset,
    input  logic por_req,
    input  logic arst_en_n,
    input  logic mode,
    output logic clr,
    output logic mode_q
);
    // Keep last cycle's mode for edge detection; it tracks mode in reset too.
    always_ff @(posedge clk) begin
        mode_q <= mode;
    end

    // A clear is master reset, an enabled power-on request or a mode change.
    always_comb begin
        clr = mreset | (por_req & ~arst_en_n) | (mode ^ mode_q);
    end
endmodule

// File: rtl/tt_counter.sv
// Two-section binary counter. The upper section is clocked by the lower
// section's carry, or directly by tick when skip_low is set.
// Assumes: clr has priority over tick.
module tt_counter #(
    parameter int LOW_W  = 8,
    parameter int HIGH_W = 8,
    localparam int CNT_W = LOW_W + HIGH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic             skip_low,
    output logic [CNT_W-1:0] count
);
    logic [LOW_W-1:0]  low_q;
    logic [HIGH_W-1:0] high_q;
    logic              high_step;

    // Upper section steps on the lower carry, or on every tick when bypassed.
    always_comb begin
        high_step = skip_low ? tick : (tick & (&low_q));
    end

    // Lower section: clears first, then counts ticks.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            low_q <= '0;
        else if (tick)
            low_q <= low_q + 1'b1;
    end

    // Upper section: clears first, then counts its step source.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            high_q <= '0;
        else if (high_step)
            high_q <= high_q + 1'b1;
    end

    assign count = {high_q, low_q};
endmodule

// File: rtl/tt_tap_mux.sv
// Picks one counter stage as the timing tap and flags the bypass code.
// Assumes: stage numbers count from 1 at the least significant bit.
module tt_tap_mux
    import tap_timer_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int STG_MID = 13,
    parameter int STG_LOW = 10
) (
    input  logic [CNT_W-1:0] count,
    input  logic             sel_a,
    input  logic             sel_b,
    output logic             tap,
    output logic             skip_low
);
    tap_sel_e code;

    // Decode the select into a stage bit; both A=1 codes take the top stage.
    always_comb begin
        code     = tap_sel_e'({sel_a, sel_b});
        skip_low = (code == TAP_SKIP);
        case (code)
            TAP_MID: tap = count[STG_MID-1];
            TAP_LOW: tap = count[STG_LOW-1];
            default: tap = count[CNT_W-1];
        endcase
    end
endmodule

// File: rtl/tt_output.sv
// Output stage: a divider pass-through or a sticky single-transition latch,
// then polarity.
// Assumes: clr covers every re-arm source.
module tt_output (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic mode,
    input  logic pol,
    input  logic tap,
    output logic fired,
    output logic q
);
    // The latch sets on the tap in single-cycle mode and holds until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            fired <= 1'b0;
        else if (!mode && tap)
            fired <= 1'b1;
    end

    // The tap is ORed in so the flip lands on the same edge as the tap.
    always_comb begin
        q = pol ^ (mode ? tap : (fired | tap));
    end
endmodule

// File: rtl/tap_timer.sv
// Programmable binary tap timer top: clear control, counter, tap select, output.
// Assumes: tick is a one-cycle count enable synchronous to clk.
module tap_timer #(
    parameter int LOW_W   = 8,
    parameter int HIGH_W  = 8,
    parameter int STG_MID = 13,
    parameter int STG_LOW = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic por_req,
    input  logic arst_en_n,
    input  logic mreset,
    input  logic sel_a,
    input  logic sel_b,
    input  logic mode,
    input  logic pol_sel,
    output logic q
);
    localparam int CNT_W = LOW_W + HIGH_W;

    logic             clr_w;
    logic             mode_q_w;
    logic             skip_w;
    logic             tap_w;
    logic             fired_w;
    logic [CNT_W-1:0] count_w;

    tt_clear_ctrl u_clr (
        .clk       (clk),
        .mreset    (mreset),
        .por_req   (por_req),
        .arst_en_n (arst_en_n),
        .mode      (mode),
        .clr       (clr_w),
        .mode_q    (mode_q_w)
    );

    tt_counter #(.LOW_W(LOW_W), .HIGH_W(HIGH_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr_w),
        .tick     (tick),
        .skip_low (skip_w),
        .count    (count_w)
    );

    tt_tap_mux #(.CNT_W(CNT_W), .STG_MID(STG_MID), .STG_LOW(STG_LOW)) u_mux (
        .count    (count_w),
        .sel_a    (sel_a),
        .sel_b    (sel_b),
        .tap      (tap_w),
        .skip_low (skip_w)
    );

    tt_output u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_w),
        .mode  (mode),
        .pol   (pol_sel),
        .tap   (tap_w),
        .fired (fired_w),
        .q     (q)
    );
endmodule

// File: rtl/tap_timer_checker.sv
// Property checker for tap_timer, attached by bind.
// Assumes: it sees the top's ports plus its count, latch, clear and mode copy.
module tap_timer_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             por_req,
    input logic             arst_en_n,
    input logic             mreset,
    input logic             mode,
    input logic             pol_sel,
    input logic             q,
    input logic             clr,
    input logic             mode_q,
    input logic             fired,
    input logic [CNT_W-1:0] count
);
    p_clear_sets_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mreset |=> (q == pol_sel && count == '0));

    p_mreset_beats_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mreset && tick) |=> (count == '0));

    p_por_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (por_req && arst_en_n && !mreset && !tick && mode == mode_q) |=> $stable(count));

    p_por_honoured_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (por_req && !arst_en_n) |=> (count == '0));

    p_idle_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(count));

    p_tick_moves_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clr) |=> (count != $past(count)));

    p_latch_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fired && !clr) |=> fired);

    p_mode_edge_rearms_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != mode_q) |=> (count == '0 && !fired));
endmodule

bind tap_timer tap_timer_checker #(.CNT_W(LOW_W + HIGH_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .por_req   (por_req),
    .arst_en_n (arst_en_n),
    .mreset    (mreset),
    .mode      (mode),
    .pol_sel   (pol_sel),
    .q         (q),
    .clr       (clr_w),
    .mode_q    (mode_q_w),
    .fired     (fired_w),
    .count     (count_w)
);

// File: tb/tap_timer_bench.sv
module tap_timer_bench;
    logic clk = 1'b0;
    logic rst_n, tick, por_req, arst_en_n, mreset, sel_a, sel_b, mode, pol_sel;
    logic q;
    int   errors = 0;
    int   checks = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    tap_timer u_tap_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .por_req(por_req),
        .arst_en_n(arst_en_n), .mreset(mreset), .sel_a(sel_a), .sel_b(sel_b),
        .mode(mode), .pol_sel(pol_sel), .q(q)
    );

    typedef struct packed {
        logic        a;
        logic        b;
        logic        md;
        logic        pol;
        logic [15:0] half;
        logic        long_hold;
    } vec_t;

    // half = 2^(n-1) from R5; long_hold walks a second half period.
    localparam vec_t VECS [14] = '{
        '{1'b0, 1'b0, 1'b1, 1'b0, 16'd4096,  1'b1},
        '{1'b0, 1'b0, 1'b1, 1'b1, 16'd4096,  1'b1},
        '{1'b0, 1'b0, 1'b0, 1'b0, 16'd4096,  1'b1},
        '{1'b0, 1'b0, 1'b0, 1'b1, 16'd4096,  1'b1},
        '{1'b0, 1'b1, 1'b1, 1'b0, 16'd512,   1'b1},
        '{1'b0, 1'b1, 1'b1, 1'b1, 16'd512,   1'b1},
        '{1'b0, 1'b1, 1'b0, 1'b0, 16'd512,   1'b1},
        '{1'b0, 1'b1, 1'b0, 1'b1, 16'd512,   1'b1},
        '{1'b1, 1'b0, 1'b1, 1'b0, 16'd128,   1'b1},
        '{1'b1, 1'b0, 1'b1, 1'b1, 16'd128,   1'b1},
        '{1'b1, 1'b0, 1'b0, 1'b0, 16'd128,   1'b1},
        '{1'b1, 1'b0, 1'b0, 1'b1, 16'd128,   1'b1},
        '{1'b1, 1'b1, 1'b0, 1'b0, 16'd32768, 1'b0},
        '{1'b1, 1'b1, 1'b1, 1'b1, 16'd32768, 1'b0}
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: q=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Holds tick high for exactly n rising edges, then returns on a falling edge.
    task automatic run_ticks(input int n);
        @(negedge clk) tick = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic setup(input logic a, input logic b, input logic md, input logic p);
        @(negedge clk);
        sel_a = a; sel_b = b; mode = md; pol_sel = p; mreset = 1'b1;
        repeat (2) @(negedge clk);
        mreset = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung, q=%b expected finish", q);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tick = 1'b0; por_req = 1'b0; arst_en_n = 1'b1; mreset = 1'b0;
        sel_a = 1'b1; sel_b = 1'b0; mode = 1'b1; pol_sel = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset level pol=1", q, 1'b1);
        pol_sel = 1'b0;
        @(negedge clk);
        check("R1 reset level pol=0", q, 1'b0);
        rst_n = 1'b1;

        // Table walk: R5 mapping, R6 divider, R7 single cycle.
        foreach (VECS[i]) begin
            setup(VECS[i].a, VECS[i].b, VECS[i].md, VECS[i].pol);
            check("R1 after mreset", q, VECS[i].pol);
            run_ticks(int'(VECS[i].half) - 1);
            check(VECS[i].md ? "R6 before edge" : "R7 before edge", q, VECS[i].pol);
            run_ticks(1);
            check("R5 first change", q, ~VECS[i].pol);
            if (VECS[i].long_hold) begin
                run_ticks(int'(VECS[i].half));
                if (VECS[i].md) check("R6 returns after half", q, VECS[i].pol);
                else            check("R7 holds after half", q, ~VECS[i].pol);
            end else begin
                run_ticks(16);
                check("R7 R6 level after 16 more", q, ~VECS[i].pol);
            end
        end

        // R4: idle cycles between ticks do not count.
        setup(1'b1, 1'b0, 1'b1, 1'b0);
        for (int k = 0; k < 127; k++) begin
            run_ticks(1);
            repeat (2) @(negedge clk);
        end
        check("R4 gated 127 ticks", q, 1'b0);
        run_ticks(1);
        check("R4 tick 128", q, 1'b1);

        // R2: mreset held with tick high gains nothing.
        @(negedge clk); pol_sel = 1'b1; mreset = 1'b1; tick = 1'b1;
        repeat (300) @(negedge clk);
        check("R2 level during mreset+tick", q, 1'b1);
        mreset = 1'b0; tick = 1'b0;
        run_ticks(127);
        check("R2 no early count", q, 1'b1);
        run_ticks(1);
        check("R2 full count after release", q, 1'b0);

        // R3: disabled power-on request is ignored.
        setup(1'b1, 1'b0, 1'b1, 1'b0);
        run_ticks(60);
        @(negedge clk); arst_en_n = 1'b1; por_req = 1'b1;
        repeat (5) @(negedge clk);
        por_req = 1'b0;
        run_ticks(67);
        check("R3 disabled por ignored, before", q, 1'b0);
        run_ticks(1);
        check("R3 disabled por ignored, at 128", q, 1'b1);

        // R3: enabled power-on request clears.
        setup(1'b1, 1'b0, 1'b1, 1'b0);
        run_ticks(60);
        @(negedge clk); arst_en_n = 1'b0; por_req = 1'b1;
        repeat (5) @(negedge clk);
        por_req = 1'b0; arst_en_n = 1'b1;
        run_ticks(127);
        check("R3 enabled por cleared, before", q, 1'b0);
        run_ticks(1);
        check("R3 enabled por cleared, at 128", q, 1'b1);

        // R8: a mode toggle re-arms single-cycle operation.
        setup(1'b1, 1'b0, 1'b0, 1'b0);
        run_ticks(128);
        run_ticks(300);
        check("R7 latched after 428", q, 1'b1);
        @(negedge clk) mode = 1'b1;
        @(negedge clk) mode = 1'b0;
        @(negedge clk);
        check("R8 re-armed level", q, 1'b0);
        run_ticks(127);
        check("R8 before new edge", q, 1'b0);
        run_ticks(1);
        check("R8 fires again", q, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule